// File: doc/BRIEF.md
# Interrupt Acceptance and Flag Control

This block keeps the processor status word of a small CPU and decides, every cycle, whether an incoming interrupt is taken. The status word is 11 bits wide. It holds the arithmetic flags (carry, zero, sign, overflow), a debug bit, a register-bank select bit, an interrupt enable bit, a stack-select bit and a 3-bit processor priority level. A hardware request is accepted only when interrupts are enabled and the request priority is strictly above the current level. A software interrupt strobe is never masked.

When an interrupt is accepted, the block raises a single-cycle accept signal and updates the status word on that same edge. It also holds two stack pointers, one for interrupts and one for user code. The stack-select bit picks which pointer is driven out and which one a pointer write reaches. The bank-select bit is brought out for the register file. Vector fetch and context saving belong to the surrounding core and are not part of this block.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, every status bit is 0. The interrupt stack pointer reads 0 on `sp_o`, `bank_o` is 0 and `accept_o` is 0.
- R2: `accept_o` is high for a hardware request only when the enable bit (bit 6) is 1 and `hw_prio_i` is strictly greater than the level field (bits 10:8). A request with equal or lower priority, or with the enable bit at 0, is not accepted.
- R3: On any accepted interrupt, the enable bit (bit 6) reads 0 after the clock edge.
- R4: A hardware acceptance clears the stack-select bit (bit 7) on the same edge.
- R5: `sw_int_i` always raises `accept_o`, whatever the enable bit and level are. A number below 32 clears bit 7. A number of 32 or above leaves bit 7 as it was.
- R6: `flg_we_i` loads all 11 bits from `flg_wdata_i`. The layout is C=0, D=1, Z=2, S=3, B=4, O=5, I=6, U=7, level=10:8.
- R7: `alu_upd_i` loads C, Z, S and O from the ALU inputs and leaves the other bits unchanged. When both strobes are high in the same cycle, `flg_we_i` wins.
- R8: The effects of acceptance are applied after a flag write or ALU update in the same cycle, so they override the written I and U values.
- R9: `sp_o` shows the user pointer when U=1 and the interrupt pointer when U=0. `sp_we_i` writes the pointer selected by the current U. `bank_o` equals bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | 1 | Hardware interrupt request |
| hw_prio_i | input | 3 | Priority of the hardware request |
| sw_int_i | input | 1 | Software interrupt strobe |
| sw_num_i | input | 6 | Software interrupt number |
| alu_upd_i | input | 1 | ALU flag update strobe |
| alu_c_i | input | 1 | ALU carry/borrow/shift-out |
| alu_z_i | input | 1 | ALU zero result |
| alu_s_i | input | 1 | ALU negative result |
| alu_o_i | input | 1 | ALU overflow |
| flg_we_i | input | 1 | Status word write strobe |
| flg_wdata_i | input | 11 | Status word write data |
| sp_we_i | input | 1 | Stack pointer write strobe |
| sp_wdata_i | input | 16 | Stack pointer write data |
| accept_o | output | 1 | Interrupt accepted this cycle |
| flags_o | output | 11 | Current status word |
| sp_o | output | 16 | Active stack pointer |
| bank_o | output | 1 | Register bank select |

## Verification
The bench builds the block with its default parameters: a 6-bit software number, a stack-select clearing limit of 32 and 16-bit pointers. With these values the whole number range 0..63 is reachable, so both sides of the limit (31 and 32) and the top value 63 are driven. Every pairing of request priority and level is also reachable, which covers the equal-priority rejection directly as well as through random stimulus.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int FLAG_W = 11;
  localparam int IPL_W  = 3;

  typedef struct packed {
    logic [IPL_W-1:0] ipl;  // 10:8
    logic u;                // 7
    logic i;                // 6
    logic o;                // 5
    logic b;                // 4
    logic s;                // 3
    logic z;                // 2
    logic d;                // 1
    logic c;                // 0
  } flags_t;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_flag_pkg::*;
#(
  parameter int SW_NUM_W   = 6,
  parameter int SW_U_LIMIT = 32
) (
  input  flags_t              flags_i,
  input  logic                hw_req_i,
  input  logic [IPL_W-1:0]    hw_prio_i,
  input  logic                sw_int_i,
  input  logic [SW_NUM_W-1:0] sw_num_i,
  output logic                accept_o,
  output logic                hw_take_o,
  output logic                clr_u_o
);
  logic sw_low;

  always_comb begin
    hw_take_o = hw_req_i && flags_i.i && (hw_prio_i > flags_i.ipl);
    sw_low    = sw_int_i && (int'(sw_num_i) < SW_U_LIMIT);
    accept_o  = hw_take_o || sw_int_i;
    clr_u_o   = hw_take_o || sw_low;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import irq_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flg_we_i,
  input  logic [FLAG_W-1:0] flg_wdata_i,
  input  logic              alu_upd_i,
  input  logic              alu_c_i,
  input  logic              alu_z_i,
  input  logic              alu_s_i,
  input  logic              alu_o_i,
  input  logic              accept_i,
  input  logic              hw_take_i,
  input  logic              clr_u_i,
  output flags_t            flags_o
);
  flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (flg_we_i) begin
      flags_d = flags_t'(flg_wdata_i);
    end else if (alu_upd_i) begin
      flags_d.c = alu_c_i;
      flags_d.z = alu_z_i;
      flags_d.s = alu_s_i;
      flags_d.o = alu_o_i;
    end
    // acceptance overrides any write in the same cycle
    if (accept_i) flags_d.i = 1'b0;
    if (clr_u_i)  flags_d.u = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r3_accept_clears_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !flags_q.i);
  a_r4_hw_clears_u: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_take_i |=> !flags_q.u);
  a_r7_alu_keeps_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && !flg_we_i && !accept_i) |=>
      (flags_q.b == $past(flags_q.b)) && (flags_q.ipl == $past(flags_q.ipl))
      && (flags_q.u == $past(flags_q.u)) && (flags_q.d == $past(flags_q.d)));
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int SP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            u_i,
  input  logic            sp_we_i,
  input  logic [SP_W-1:0] sp_wdata_i,
  output logic [SP_W-1:0] sp_o
);
  logic [SP_W-1:0] isp_q, usp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isp_q <= '0;
      usp_q <= '0;
    end else if (sp_we_i) begin
      if (u_i) usp_q <= sp_wdata_i;
      else     isp_q <= sp_wdata_i;
    end
  end

  assign sp_o = u_i ? usp_q : isp_q;

  a_r9_isp_untouched_in_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u_i |=> isp_q == $past(isp_q));
  a_r9_usp_untouched_in_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !u_i |=> usp_q == $past(usp_q));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int SW_NUM_W   = 6,
  parameter int SW_U_LIMIT = 32,
  parameter int SP_W       = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_req_i,
  input  logic [IPL_W-1:0]    hw_prio_i,
  input  logic                sw_int_i,
  input  logic [SW_NUM_W-1:0] sw_num_i,
  input  logic                alu_upd_i,
  input  logic                alu_c_i,
  input  logic                alu_z_i,
  input  logic                alu_s_i,
  input  logic                alu_o_i,
  input  logic                flg_we_i,
  input  logic [FLAG_W-1:0]   flg_wdata_i,
  input  logic                sp_we_i,
  input  logic [SP_W-1:0]     sp_wdata_i,
  output logic                accept_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic [SP_W-1:0]     sp_o,
  output logic                bank_o
);
  flags_t flags;
  logic   hw_take, clr_u;

  irq_accept #(.SW_NUM_W(SW_NUM_W), .SW_U_LIMIT(SW_U_LIMIT)) u_accept (
    .flags_i   (flags),
    .hw_req_i  (hw_req_i),
    .hw_prio_i (hw_prio_i),
    .sw_int_i  (sw_int_i),
    .sw_num_i  (sw_num_i),
    .accept_o  (accept_o),
    .hw_take_o (hw_take),
    .clr_u_o   (clr_u)
  );

  flag_reg u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flg_we_i    (flg_we_i),
    .flg_wdata_i (flg_wdata_i),
    .alu_upd_i   (alu_upd_i),
    .alu_c_i     (alu_c_i),
    .alu_z_i     (alu_z_i),
    .alu_s_i     (alu_s_i),
    .alu_o_i     (alu_o_i),
    .accept_i    (accept_o),
    .hw_take_i   (hw_take),
    .clr_u_i     (clr_u),
    .flags_o     (flags)
  );

  sp_bank #(.SP_W(SP_W)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .u_i        (flags.u),
    .sp_we_i    (sp_we_i),
    .sp_wdata_i (sp_wdata_i),
    .sp_o       (sp_o)
  );

  assign flags_o = flags;
  assign bank_o  = flags.b;

  a_r2_masked_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_int_i && !flags.i) |-> !accept_o);
  a_r2_equal_prio_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_int_i && hw_prio_i == flags.ipl) |-> !accept_o);
  a_r5_sw_always_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_int_i |-> accept_o);
  a_r5_high_num_keeps_u: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_int_i && int'(sw_num_i) >= SW_U_LIMIT && !hw_take && !flg_we_i)
      |=> flags.u == $past(flags.u));
endmodule

// File: tb/irq_flag_unit_bench.sv
module irq_flag_unit_bench;
  import irq_flag_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hw_req = 0, sw_int = 0, alu_upd = 0, ac = 0, az = 0, as_ = 0, ao = 0;
  logic        flg_we = 0, sp_we = 0;
  logic [2:0]  hw_prio = 0;
  logic [5:0]  sw_num = 0;
  logic [10:0] flg_wd = 0;
  logic [15:0] sp_wd = 0;
  logic        accept, bank;
  logic [10:0] flags;
  logic [15:0] sp;

  flags_t      m_f;
  logic [15:0] m_isp, m_usp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_flag_unit u_irq_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .hw_prio_i(hw_prio),
    .sw_int_i(sw_int), .sw_num_i(sw_num), .alu_upd_i(alu_upd), .alu_c_i(ac),
    .alu_z_i(az), .alu_s_i(as_), .alu_o_i(ao), .flg_we_i(flg_we),
    .flg_wdata_i(flg_wd), .sp_we_i(sp_we), .sp_wdata_i(sp_wd),
    .accept_o(accept), .flags_o(flags), .sp_o(sp), .bank_o(bank)
  );

  function automatic logic exp_hw(flags_t f);
    return hw_req && f.i && (hw_prio > f.ipl);
  endfunction

  function automatic flags_t exp_next(flags_t f);
    flags_t n = f;
    if (flg_we) n = flags_t'(flg_wd);
    else if (alu_upd) begin n.c = ac; n.z = az; n.s = as_; n.o = ao; end
    if (exp_hw(f) || sw_int) n.i = 1'b0;
    if (exp_hw(f) || (sw_int && sw_num < 6'd32)) n.u = 1'b0;
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // inputs already driven at negedge; check, then advance one edge
  task automatic cycle(string tag);
    #1;
    chk(tag, "accept", 16'(accept), 16'(exp_hw(m_f) || sw_int));
    chk(tag, "flags", 16'(flags), 16'(m_f));
    chk(tag, "sp", sp, m_f.u ? m_usp : m_isp);
    chk(tag, "bank", 16'(bank), 16'(m_f.b));
    @(posedge clk);
    if (sp_we) begin
      if (m_f.u) m_usp = sp_wd; else m_isp = sp_wd;
    end
    m_f = exp_next(m_f);
    @(negedge clk);
    {hw_req, sw_int, alu_upd, flg_we, sp_we} = '0;
  endtask

  function automatic logic [10:0] mk(logic [2:0] ipl, logic u, logic i, logic b);
    flags_t f = '0;
    f.ipl = ipl; f.u = u; f.i = i; f.b = b;
    return 11'(f);
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    m_f = '0; m_isp = '0; m_usp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycle("R1");

    // R6: write I=1, U=1, level 3, B=1
    flg_we = 1; flg_wd = mk(3'd3, 1, 1, 1); cycle("R6");
    // R9: user pointer written while U=1
    sp_we = 1; sp_wd = 16'hbeef; cycle("R9");
    // R2: equal priority rejected
    hw_req = 1; hw_prio = 3'd3; cycle("R2");
    // R2/R4: higher priority taken, clears I and U
    hw_req = 1; hw_prio = 3'd4; cycle("R2");
    cycle("R3");
    chk("R4", "u", 16'(flags[7]), 16'd0);
    // R9: interrupt pointer written while U=0
    sp_we = 1; sp_wd = 16'h1234; cycle("R9");
    // R2: disabled, top priority rejected
    hw_req = 1; hw_prio = 3'd7; cycle("R2");
    // R5: sw number 32 with U=1 keeps U
    flg_we = 1; flg_wd = mk(3'd7, 1, 0, 0); cycle("R6");
    sw_int = 1; sw_num = 6'd32; cycle("R5");
    chk("R5", "u_kept", 16'(flags[7]), 16'd1);
    sw_int = 1; sw_num = 6'd63; cycle("R5");
    sw_int = 1; sw_num = 6'd31; cycle("R5");
    chk("R5", "u_cleared", 16'(flags[7]), 16'd0);
    // R7: ALU update alone, then collision with write
    alu_upd = 1; {ac, az, as_, ao} = 4'b1011; cycle("R7");
    alu_upd = 1; {ac, az, as_, ao} = 4'b0100;
    flg_we = 1; flg_wd = mk(3'd1, 1, 1, 0); cycle("R7");
    chk("R7", "write_wins", 16'(flags), 16'(mk(3'd1, 1, 1, 0)));
    // R8: write I=1,U=1 in same cycle as sw 0
    flg_we = 1; flg_wd = mk(3'd2, 1, 1, 1); sw_int = 1; sw_num = 6'd0; cycle("R8");
    chk("R8", "i_u_cleared", 16'(flags[7:6]), 16'd0);

    for (int n = 0; n < 4000; n++) begin
      hw_req  = $urandom_range(0, 1);
      hw_prio = 3'($urandom);
      sw_int  = ($urandom_range(0, 9) == 0);
      sw_num  = 6'($urandom);
      alu_upd = $urandom_range(0, 1);
      {ac, az, as_, ao} = 4'($urandom);
      flg_we  = ($urandom_range(0, 3) == 0);
      flg_wd  = 11'($urandom);
      sp_we   = $urandom_range(0, 1);
      sp_wd   = 16'($urandom);
      cycle("R6");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule